// File: doc/BRIEF.md
# Trigger-Capture Cascaded Timestamp Counter

The block keeps a free-running cycle count split into two equal halves. The lower half counts every clock. The upper half is advanced by a registered link taken from the lower half's top bit, and an edge detector watches that link. Because of this, the upper half updates two cycles after the lower half rolls over. During those two cycles the pair of halves, read as they stand, would show a value that is one full lower-half period too small.

An external trigger line passes through a synchronizer and is watched by a capture sequencer. Once the line has been seen low, the next high level starts one capture. The sequencer reads the halves one at a time through a shared read mux, in this order: upper, lower, one settle cycle, then upper again. If the two upper reads agree, the first pair is reported. If they disagree, the lower half is read once more and reported together with the second upper value. The result lands in two output registers and is flagged by a one-cycle valid pulse.

Top module: `trig_capture_timer`

## Requirements
- R1: The lower half starts at zero after reset and increases by one on every clock, wrapping from all-ones to zero. A capture whose halves agree reports the count that was present four clocks after the trigger was first driven high.
- R2: The upper half changes only on the clock where the lower half goes from 1 to 2 just after a wrap, so the carry is applied two cycles after the wrap.
- R3: A capture is armed only after the synchronized trigger has been seen low. A trigger that is already high when reset is released causes no capture until it has gone low.
- R4: A trigger held high produces exactly one capture. No further valid pulse occurs until it has gone low and then high again.
- R5: When both upper-half reads agree, the result is the first upper read and the lower read, and valid rises seven clocks after the trigger is driven high.
- R6: When the upper-half reads differ, the lower half is read again and reported with the second upper read, and valid rises eight clocks after the trigger.
- R7: The reported pair {upper, lower} always equals the true number of clocks since reset at the moment the reported lower value was read. It is never one lower-half period short, even when the trigger lands next to a rollover.
- R8: The valid strobe lasts exactly one clock, and both result registers keep their value until the next capture.
- R9: Synchronous active-high reset clears both halves, the carry link, the result registers and valid, and returns the sequencer to waiting for a low trigger.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger line, active high |
| ts_hi | output | HALF_W | Upper half of the captured timestamp |
| ts_lo | output | HALF_W | Lower half of the captured timestamp |
| ts_valid | output | 1 | One-clock strobe marking a new result |

## Verification
The bench runs with a narrow half so the lower counter wraps every 256 clocks. It places the trigger at each phase from six clocks before a rollover to two clocks after it, plus one phase far from any rollover. The phases that put the lower read inside the stale-carry window must take the retry path: they differ from their neighbours in both valid latency and reported lower value, which separates a working re-read from a plain snapshot and from an off-by-one carry delay. Directed cases cover a trigger held high, a trigger that is already high at reset release, and a reset applied mid-run followed by a capture near zero.

// File: rtl/trig_capture_timer_pkg.sv
package trig_capture_timer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE_WAIT = 3'd0,
      ST_ARMED     = 3'd1,
      ST_READ_HI1  = 3'd2,
      ST_READ_LO   = 3'd3,
      ST_SETTLE    = 3'd4,
      ST_READ_HI2  = 3'd5,
      ST_REREAD_LO = 3'd6,
      ST_DONE      = 3'd7
   } cap_state_t;

endpackage

// File: rtl/ct_cascade_counter.sv
module ct_cascade_counter #(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_hi,
   output logic [HALF_W-1:0] rd_data
);
   localparam int MSB = HALF_W - 1;

   logic [HALF_W-1:0] lo_q;
   logic [HALF_W-1:0] hi_q;
   logic              link_q;
   logic              link_prev_q;
   logic              carry_en;

   generate
      if (HALF_W < 4) begin : g_bad_width
         $error("ct_cascade_counter: HALF_W must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q <= '0;
      end else begin
         lo_q <= lo_q + 1'b1;
      end
   end

   // link register followed by the edge-detect flop
   always_ff @(posedge clk) begin
      if (rst) begin
         link_q      <= 1'b0;
         link_prev_q <= 1'b0;
      end else begin
         link_q      <= lo_q[MSB];
         link_prev_q <= link_q;
      end
   end

   assign carry_en = link_prev_q & ~link_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
      end else if (carry_en) begin
         hi_q <= hi_q + 1'b1;
      end
   end

   assign rd_data = rd_hi ? hi_q : lo_q;

   assert_lo_step_R1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> lo_q == $past(lo_q) + 1'b1);

   assert_hi_late_carry_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(hi_q) |-> (lo_q == HALF_W'(2)));

endmodule

// File: rtl/ct_trig_sync.sv
module ct_trig_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_in,
   output logic trig_s
);
   logic [SYNC_STAGES-1:0] chain_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("ct_trig_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // reset to the active level so arming needs a genuine low
   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q[0] <= 1'b1;
      end else begin
         chain_q[0] <= trig_in;
      end
   end

   generate
      for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) begin
               chain_q[i] <= 1'b1;
            end else begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign trig_s = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/ct_capture_seq.sv
module ct_capture_seq
   import trig_capture_timer_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig_s,
   input  logic [HALF_W-1:0] rd_data,
   output logic              rd_hi,
   output logic [HALF_W-1:0] ts_hi,
   output logic [HALF_W-1:0] ts_lo,
   output logic              ts_valid
);
   cap_state_t        state_q;
   logic [HALF_W-1:0] hi1_q;
   logic [HALF_W-1:0] hi2_q;
   logic [HALF_W-1:0] lo1_q;

   assign rd_hi = (state_q == ST_READ_HI1) || (state_q == ST_READ_HI2);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE_WAIT;
         hi1_q    <= '0;
         hi2_q    <= '0;
         lo1_q    <= '0;
         ts_hi    <= '0;
         ts_lo    <= '0;
         ts_valid <= 1'b0;
      end else begin
         ts_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE_WAIT: if (!trig_s) state_q <= ST_ARMED;
            ST_ARMED:     if (trig_s)  state_q <= ST_READ_HI1;
            ST_READ_HI1: begin
               hi1_q   <= rd_data;
               state_q <= ST_READ_LO;
            end
            ST_READ_LO: begin
               lo1_q   <= rd_data;
               state_q <= ST_SETTLE;
            end
            ST_SETTLE:    state_q <= ST_READ_HI2;
            ST_READ_HI2: begin
               if (rd_data != hi1_q) begin
                  hi2_q   <= rd_data;
                  state_q <= ST_REREAD_LO;
               end else begin
                  ts_hi    <= hi1_q;
                  ts_lo    <= lo1_q;
                  ts_valid <= 1'b1;
                  state_q  <= ST_DONE;
               end
            end
            ST_REREAD_LO: begin
               ts_hi    <= hi2_q;
               ts_lo    <= rd_data;
               ts_valid <= 1'b1;
               state_q  <= ST_DONE;
            end
            ST_DONE:      state_q <= ST_IDLE_WAIT;
            default:      state_q <= ST_IDLE_WAIT;
         endcase
      end
   end

   assert_arm_needs_low_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ARMED && $past(state_q) == ST_IDLE_WAIT) |-> !$past(trig_s));

   assert_retry_on_mismatch_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_REREAD_LO) |-> (hi2_q != hi1_q));

   assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
      ts_valid |=> !ts_valid);

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ts_valid |-> ($stable(ts_hi) && $stable(ts_lo)));

endmodule

// File: rtl/trig_capture_timer.sv
module trig_capture_timer #(
   parameter int HALF_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig_in,
   output logic [HALF_W-1:0] ts_hi,
   output logic [HALF_W-1:0] ts_lo,
   output logic              ts_valid
);
   logic              rd_hi;
   logic [HALF_W-1:0] rd_data;
   logic              trig_s;

   ct_cascade_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .rd_hi   (rd_hi),
      .rd_data (rd_data)
   );

   ct_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .trig_in (trig_in),
      .trig_s  (trig_s)
   );

   ct_capture_seq #(.HALF_W(HALF_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .trig_s   (trig_s),
      .rd_data  (rd_data),
      .rd_hi    (rd_hi),
      .ts_hi    (ts_hi),
      .ts_lo    (ts_lo),
      .ts_valid (ts_valid)
   );

endmodule

// File: tb/trig_capture_timer_test.sv
module trig_capture_timer_test;
   localparam int W  = 8;
   localparam int NV = 10;
   localparam logic [W-1:0] PHASE [NV] = '{8'd250, 8'd251, 8'd252, 8'd253,
      8'd254, 8'd255, 8'd0, 8'd1, 8'd2, 8'd100};
   localparam bit RETRY [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
      1'b0, 1'b0, 1'b0};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         trig_in = 1'b0;
   logic [W-1:0] ts_hi, ts_lo;
   logic         ts_valid;
   logic [63:0]  tc;
   int           n_chk = 0;
   int           n_fail = 0;

   trig_capture_timer #(.HALF_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .trig_in(trig_in),
      .ts_hi(ts_hi), .ts_lo(ts_lo), .ts_valid(ts_valid)
   );

   always #5 clk = ~clk;

   always_ff @(posedge clk) begin
      if (rst) tc <= '0;
      else     tc <= tc + 64'd1;
   end

   task automatic check(input bit ok, input string req, input longint act,
                        input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // trigger at current negedge; returns cycles to valid (0 = none in 12)
   task automatic fire(output int lat, output longint t0);
      t0 = longint'(tc);
      trig_in = 1'b1;
      lat = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (ts_valid) begin
            lat = i;
            break;
         end
      end
   endtask

   task automatic no_valid(input int cycles, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (ts_valid) seen = 1'b1;
      end
      check(!seen, req, longint'(seen), 0);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int     lat;
      longint t0, ex;
      logic [W-1:0] hold_hi, hold_lo;

      repeat (3) @(negedge clk);
      // R9: reset state
      check(ts_valid == 1'b0, "R9 valid in reset", ts_valid, 0);
      check(ts_hi == '0 && ts_lo == '0, "R9 result in reset", {ts_hi, ts_lo}, 0);
      rst = 1'b0;
      repeat (6) @(negedge clk);

      // table walk: trigger placed around lower-half rollovers
      for (int v = 0; v < NV; v++) begin
         while (tc[W-1:0] != PHASE[v]) @(negedge clk);
         fire(lat, t0);
         ex = RETRY[v] ? t0 + 7 : t0 + 4;
         if (RETRY[v])
            check(lat == 8, "R6 retry latency", lat, 8);
         else
            check(lat == 7, "R5 direct latency", lat, 7);
         // R7 / R1 / R2: untorn value equal to true count
         check({ts_hi, ts_lo} == ex[2*W-1:0], "R7 timestamp value",
               longint'({ts_hi, ts_lo}), ex & 64'hFFFF);
         hold_hi = ts_hi;
         hold_lo = ts_lo;
         @(negedge clk);
         check(ts_valid == 1'b0, "R8 single pulse", ts_valid, 0);
         // R4: trigger still high, no further capture
         no_valid(6, "R4 held trigger");
         check(ts_hi == hold_hi && ts_lo == hold_lo, "R8 result hold",
               longint'({ts_hi, ts_lo}), longint'({hold_hi, hold_lo}));
         trig_in = 1'b0;
         repeat (5) @(negedge clk);
      end

      // R4: long held trigger gives one capture only
      fire(lat, t0);
      check(lat == 7, "R4 first capture", lat, 7);
      no_valid(40, "R4 long hold");
      trig_in = 1'b0;
      repeat (5) @(negedge clk);

      // R3: trigger high across reset release
      trig_in = 1'b1;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(ts_hi == '0 && ts_lo == '0 && !ts_valid, "R9 mid-run reset",
            longint'({ts_hi, ts_lo}), 0);
      rst = 1'b0;
      no_valid(20, "R3 high at reset release");
      trig_in = 1'b0;
      repeat (5) @(negedge clk);

      // R1 / R9: counter restarted from zero
      fire(lat, t0);
      check(lat == 7, "R3 capture after low", lat, 7);
      ex = t0 + 4;
      check({ts_hi, ts_lo} == ex[2*W-1:0], "R1 count after reset",
            longint'({ts_hi, ts_lo}), ex & 64'hFFFF);
      check(t0 < 64, "R9 counter cleared", t0, 30);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule